// File: doc/BRIEF.md
# Peripheral Bus Line Latch

This block sits between a CPU's bit-addressed I/O space and a six-line peripheral bus with four data lines, an active-low handshake line and an active-low bus-available line. Software sets or clears one outbound line per I/O write. A write to the handshake or bus-available line pushes the whole outbound byte onto the bus, but only when that write changes the outbound byte. The bus has no interrupt path, so software polls a packed 8-bit read value built from an inbound latch.

The inbound latch follows the bus only under three conditions: capture must be enabled, the block's own outbound bus-available bit must be low, and the synchronised bus value must have just changed. An inhibit control forces the inbound latch back to its idle pattern and stops capture. The inhibit is active out of reset. A handshake or bus-available write that changes the outbound byte clears it. Both latches use an 8-bit line layout. From bit 7 down to bit 0 it is: data3, data2, unused (0), handshake_n, constant 0, avail_n, data1, data0. The idle value is D7h.

Top module: `port_line_latch`

## Requirements
- R1: After reset, `bus_o` is D7h, `rd_data_o` is 7Fh, and capture is disabled, so bus changes leave `rd_data_o` at 7Fh.
- R2: A write with `wr_sel_i` 0, 1, 2 or 3 loads `wr_bit_i` into outbound bit 0, 1, 6 or 7. It does not change `bus_o`.
- R3: A write with `wr_sel_i` 4 loads outbound bit 4 (handshake_n), and `wr_sel_i` 5 loads bit 2 (avail_n). If the outbound byte then differs from its value before the write, `bus_o` takes the new byte on the next clock. Otherwise `bus_o` keeps its value.
- R4: A write under R3 that changes the outbound byte also enables capture.
- R5: A write with `wr_sel_i` 6 and `wr_bit_i` 1 sets the inbound latch to D7h and disables capture. With `wr_bit_i` 0 it enables capture.
- R6: `bus_i` passes through two synchroniser flip-flops. The inbound latch loads the synchronised value on the third rising edge after `bus_i` changes. This happens only if capture is enabled, outbound avail_n is 0, and the synchronised value differs from the one before it. A value that stays the same is never captured.
- R7: `rd_data_o` bits 0 to 5 are inbound bits 0, 1, 6, 7, 4 and 2 (data0, data1, data2, data3, handshake_n, avail_n). Bit 6 reads 1 and bit 7 reads 0.
- R8: Outbound bits 3 and 5 are always 0.
- R9: An inhibit write in the same cycle as a capture wins: the inbound latch becomes D7h. A write with `wr_sel_i` 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | I/O bit write strobe |
| wr_sel_i | input | 3 | Written line: 0-3 data, 4 handshake_n, 5 avail_n, 6 inhibit, 7 spare |
| wr_bit_i | input | 1 | Written bit value |
| bus_i | input | 8 | Sampled bus lines, latch layout |
| bus_o | output | 8 | Driven bus lines, latch layout |
| rd_data_o | output | 8 | Packed polled read value |

## Verification
Two functions can land in the same clock: an inhibit write and a capture of a changed bus value. The bench provokes this by changing `bus_i` and then placing an inhibit write so that the strobe sits on the third rising edge after the change, which is the capture edge. It then expects `rd_data_o` to read 7Fh, not the mapped bus value. Separately, a bus value is repeated across an inhibit cycle, and the bench confirms that an unchanged synchronised value is not recaptured.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  localparam int unsigned LINE_W    = 8;
  localparam int unsigned NUM_LINES = 6;
  localparam int unsigned SEL_W     = 3;
  localparam logic [LINE_W-1:0] IDLE_VAL = 8'hD7;
  localparam int unsigned AVAIL_POS = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_D0    = 3'd0,
    SEL_D1    = 3'd1,
    SEL_D2    = 3'd2,
    SEL_D3    = 3'd3,
    SEL_HS    = 3'd4,
    SEL_AV    = 3'd5,
    SEL_INH   = 3'd6,
    SEL_SPARE = 3'd7
  } sel_e;

  // line index -> bit position in the latch byte
  function automatic logic [2:0] line_pos(input logic [SEL_W-1:0] idx);
    case (idx)
      3'd0:    line_pos = 3'd0;
      3'd1:    line_pos = 3'd1;
      3'd2:    line_pos = 3'd6;
      3'd3:    line_pos = 3'd7;
      3'd4:    line_pos = 3'd4;
      3'd5:    line_pos = 3'd2;
      default: line_pos = 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/pbl_sync.sv
module pbl_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pbl_out_latch.sv
module pbl_out_latch
  import pbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_bit_i,
  output logic [LINE_W-1:0] lat_o,
  output logic [LINE_W-1:0] bus_o,
  output logic              drive_o
);
  logic [LINE_W-1:0] lat_q, lat_nxt, bus_q;
  logic              line_wr, ctl_wr;

  assign line_wr = wr_en_i && (wr_sel_i < SEL_W'(NUM_LINES));
  assign ctl_wr  = wr_en_i && ((wr_sel_i == SEL_HS) || (wr_sel_i == SEL_AV));

  always_comb begin
    lat_nxt = lat_q;
    if (line_wr) lat_nxt[line_pos(wr_sel_i)] = wr_bit_i;
  end

  assign drive_o = ctl_wr && (lat_nxt != lat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= IDLE_VAL;
      bus_q <= IDLE_VAL;
    end else begin
      lat_q <= lat_nxt;
      if (drive_o) bus_q <= lat_nxt;
    end
  end

  assign lat_o = lat_q;
  assign bus_o = bus_q;
endmodule

// File: rtl/pbl_in_latch.sv
module pbl_in_latch
  import pbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_bit_i,
  input  logic              drive_i,
  input  logic [LINE_W-1:0] out_lat_i,
  input  logic [LINE_W-1:0] bus_sync_i,
  output logic [LINE_W-1:0] in_lat_o,
  output logic              inhibit_o
);
  logic [LINE_W-1:0] prev_q, in_q;
  logic              inh_q, inh_wr, changed, capture;

  assign inh_wr  = wr_en_i && (wr_sel_i == SEL_INH);
  assign changed = (bus_sync_i != prev_q);
  // gate uses pre-write state; a same-cycle inhibit set overrides capture
  assign capture = changed && !inh_q && !out_lat_i[AVAIL_POS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= IDLE_VAL;
      in_q   <= IDLE_VAL;
      inh_q  <= 1'b1;
    end else begin
      prev_q <= bus_sync_i;
      if (inh_wr) inh_q <= wr_bit_i;
      else if (drive_i) inh_q <= 1'b0;
      if (inh_wr && wr_bit_i) in_q <= IDLE_VAL;
      else if (capture) in_q <= bus_sync_i;
    end
  end

  assign in_lat_o  = in_q;
  assign inhibit_o = inh_q;
endmodule

// File: rtl/port_line_latch.sv
module port_line_latch
  import pbl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_bit_i,
  input  logic [LINE_W-1:0] bus_i,
  output logic [LINE_W-1:0] bus_o,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [LINE_W-1:0] out_lat_q, in_lat_q, bus_sync;
  logic              drive_ev, inhibit_q;

  pbl_sync #(.STAGES(SYNC_STAGES), .W(LINE_W), .RST_VAL(IDLE_VAL)) u_sync (
    .clk_i, .rst_ni, .d_i(bus_i), .q_o(bus_sync)
  );

  pbl_out_latch u_out (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_bit_i,
    .lat_o(out_lat_q), .bus_o(bus_o), .drive_o(drive_ev)
  );

  pbl_in_latch u_in (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_bit_i,
    .drive_i(drive_ev), .out_lat_i(out_lat_q), .bus_sync_i(bus_sync),
    .in_lat_o(in_lat_q), .inhibit_o(inhibit_q)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_rd
    assign rd_data_o[i] = in_lat_q[line_pos(SEL_W'(i))];
  end
  assign rd_data_o[6] = 1'b1;
  assign rd_data_o[7] = 1'b0;
endmodule

// File: rtl/pbl_latch_chk.sv
module pbl_latch_chk
  import pbl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic              wr_bit_i,
  input logic [LINE_W-1:0] bus_o,
  input logic [LINE_W-1:0] rd_data_o,
  input logic [LINE_W-1:0] out_lat,
  input logic              inhibit
);
  p_drive_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_o) |-> $past(wr_en_i && (wr_sel_i == SEL_HS || wr_sel_i == SEL_AV)));

  p_drive_lift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && (wr_sel_i == SEL_HS || wr_sel_i == SEL_AV)) && (out_lat != $past(out_lat)))
      |-> (!inhibit && bus_o == out_lat));

  p_inhibit_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_sel_i == SEL_INH && wr_bit_i) |-> (rd_data_o == 8'h7F && inhibit));

  p_capture_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rd_data_o) && !$past(wr_en_i && wr_sel_i == SEL_INH && wr_bit_i))
      |-> $past(!inhibit && !out_lat[AVAIL_POS]));

  p_fixed_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_lat[3] == 1'b0) && (out_lat[5] == 1'b0) && (bus_o[3] == 1'b0) && (bus_o[5] == 1'b0));

  p_spare_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_sel_i == SEL_SPARE) |-> ($stable(bus_o) && $stable(out_lat) && $stable(inhibit)));
endmodule

bind port_line_latch pbl_latch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_bit_i(wr_bit_i), .bus_o(bus_o), .rd_data_o(rd_data_o),
  .out_lat(out_lat_q), .inhibit(inhibit_q)
);

// File: tb/port_line_latch_tb_top.sv
module port_line_latch_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic       wr_bit_i = 1'b0;
  logic [7:0] bus_i = 8'hD7;
  logic [7:0] bus_o, rd_data_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] m_lat = 8'hD7, m_bus = 8'hD7, m_in = 8'hD7, m_prev = 8'hD7;
  logic       m_inh = 1'b1;

  always #2.5 clk_i = ~clk_i;

  port_line_latch dut_i (.*);

  function automatic logic [2:0] pos(input int s);
    case (s)
      0: pos = 3'd0; 1: pos = 3'd1; 2: pos = 3'd6;
      3: pos = 3'd7; 4: pos = 3'd4; default: pos = 3'd2;
    endcase
  endfunction

  function automatic logic [7:0] rmap(input logic [7:0] v);
    rmap = {1'b0, 1'b1, v[2], v[4], v[7], v[6], v[1], v[0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input logic b);
    logic [7:0] nl;
    wr_en_i = 1'b1; wr_sel_i = 3'(s); wr_bit_i = b;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    nl = m_lat;
    if (s < 6) nl[pos(s)] = b;
    if ((s == 4 || s == 5) && nl != m_lat) begin m_bus = nl; m_inh = 1'b0; end
    if (s == 6) begin m_inh = b; if (b) m_in = 8'hD7; end
    m_lat = nl;
  endtask

  task automatic setbus(input logic [7:0] v);
    bus_i = v;
    repeat (3) @(negedge clk_i);
    if (v != m_prev && !m_inh && !m_lat[2]) m_in = v;
    m_prev = v;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 bus_o", bus_o, 8'hD7);
    chk("R1 rd", rd_data_o, 8'h7F);
    setbus(8'h00);
    chk("R1 inhibited at reset", rd_data_o, 8'h7F);

    // R2/R3/R8: sweep every line write, each bit value
    for (int s = 0; s < 6; s++) begin
      for (int b = 1; b >= 0; b--) begin
        wr(s, 1'(b));
        chk((s < 4) ? "R2 data line" : "R3 ctl line", bus_o, m_bus);
      end
    end
    // R2: data write alone never drives
    wr(0, 1'b1);
    chk("R2 no drive", bus_o, m_bus);
    // R3/R4: avail_n now 0 and capture enabled; sweep all bus values (R6, R7)
    wr(5, 1'b1);
    wr(5, 1'b0);
    chk("R3 avail low driven", bus_o, m_bus);
    for (int v = 0; v < 256; v++) begin
      setbus(8'(v));
      chk("R6 R7 capture sweep", rd_data_o, rmap(m_in));
    end
    // R6: avail_n high blocks capture
    wr(5, 1'b1);
    setbus(8'h3C);
    chk("R6 avail high", rd_data_o, rmap(m_in));
    // R5: inhibit set
    wr(6, 1'b1);
    chk("R5 inhibit idle", rd_data_o, 8'h7F);
    // R4: changing ctl write lifts inhibit
    wr(5, 1'b0);
    chk("R4 drive", bus_o, m_bus);
    setbus(8'h81);
    chk("R4 capture after lift", rd_data_o, rmap(m_in));
    // R3: unchanged ctl write keeps inhibit
    wr(6, 1'b1);
    wr(4, m_lat[4]);
    chk("R3 no change no drive", bus_o, m_bus);
    setbus(8'h42);
    chk("R3 inhibit kept", rd_data_o, 8'h7F);
    // R5: enable via inhibit 0; unchanged value not recaptured (R6)
    wr(6, 1'b0);
    setbus(8'h42);
    chk("R6 unchanged not captured", rd_data_o, 8'h7F);
    setbus(8'h18);
    chk("R5 enable capture", rd_data_o, rmap(m_in));
    // R9: inhibit write on the capture edge
    bus_i = 8'hE5;
    @(negedge clk_i);
    @(negedge clk_i);
    wr(6, 1'b1);
    m_prev = 8'hE5;
    chk("R9 inhibit beats capture", rd_data_o, 8'h7F);
    wr(6, 1'b0);
    // R9: spare select ignored
    wr(7, 1'b1);
    chk("R9 spare bus", bus_o, m_bus);
    setbus(8'h66);
    chk("R9 spare rd", rd_data_o, rmap(m_in));
    wr(7, 1'b0);
    chk("R9 spare bus 0", bus_o, m_bus);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule